// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Bank

This block keeps the interrupt state of an I2C controller. Ten of the twelve interrupt sources are single-cycle event pulses that the block latches into a raw status word. The other two are level conditions: the receive FIFO above its threshold, and the transmit FIFO at or below its threshold. The block derives these two from the FIFO fill levels and two threshold registers. A mask register selects which raw bits reach the visible status word, and a single interrupt line is high whenever any visible bit is set.

Software clears a latched source by reading its own clear address, or clears all of them with one read of a shared clear address. When a transmit abort is flagged, the block also captures the reason vector for that abort. The vector stays readable until the abort is cleared, so software can read why the transfer failed before it acknowledges the abort. Register reads return data on the cycle after the read strobe.

Top module: `i2c_irq_bank`

## Requirements
- R1: After a synchronous reset, the raw status, visible status, mask, abort reason and both thresholds read zero, and `irq_o` is low.
- R2: A pulse on `evt_pulse_i[k]` sets raw status bit k, and the bit stays set until it is cleared. Source bits are: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Pulses on bits 2 and 4 are ignored.
- R3: The visible status at 0x2C is the raw status at 0x34 ANDed with the mask at 0x30, which is written through bits 11:0. `irq_o` is the OR of the visible status and changes on the same clock edge as the status.
- R4: A read of a per-source clear address clears only that source's latched bit and returns that bit's previous value in bit 0. The addresses are: 0x44 bit 0, 0x48 bit 1, 0x4C bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5C bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11.
- R5: A read of 0x40 clears every latched bit and the abort reason, and returns zero.
- R6: If an event pulse arrives in the same cycle as a read that clears its bit, the bit stays set.
- R7: A pulse on bit 6 ORs `abrt_reason_i` into the abort reason register at 0x80. Only reason bits 0 to 5, 7 and 9 to 11 are kept; bits 6 and 8 always read zero. The register holds its value until a read of 0x54 or 0x40. If an abort arrives in the same cycle as such a read, the register ends up holding only the new reason.
- R8: Raw bit 2 is high when `rx_level_i` is greater than the receive threshold at 0x38. Raw bit 4 is high when `tx_level_i` is at or below the transmit threshold at 0x3C. Both lag the inputs by one clock, and clear reads do not change them.
- R9: Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`. Unmapped addresses read zero. Writes to any address other than 0x30, 0x38 and 0x3C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rd_i | input | 1 | Read strobe (clear addresses act on it) |
| reg_rdata_o | output | DATA_W | Read data, registered |
| evt_pulse_i | input | 12 | Event pulses, one per source bit |
| abrt_reason_i | input | 12 | Abort reason vector, sampled with the abort pulse |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The critical collision is an event pulse landing in the same cycle as the read that clears it. The same hazard exists for an abort pulse that coincides with a read of the abort-clear or clear-all address. The bench drives both the pulse and the read strobe on one falling edge, so the set and the clear meet at the same rising edge. It then reads the raw status and the abort reason back through the register port. The race is judged correct if the latched bit survives and the reason register holds exactly the new reason, while the clear read itself returns the bit's previous state.

// File: rtl/i2c_irq_bank_pkg.sv
package i2c_irq_bank_pkg;

  localparam int NSRC = 12;

  // source bit positions (software decodes these)
  localparam int SB_RX_UNDER  = 0;
  localparam int SB_RX_OVER   = 1;
  localparam int SB_RX_THRESH = 2;
  localparam int SB_TX_OVER   = 3;
  localparam int SB_TX_THRESH = 4;
  localparam int SB_RD_REQ    = 5;
  localparam int SB_TX_ABORT  = 6;
  localparam int SB_RX_DONE   = 7;
  localparam int SB_ACTIVITY  = 8;
  localparam int SB_STOP_SEEN = 9;
  localparam int SB_STRT_SEEN = 10;
  localparam int SB_GEN_CALL  = 11;

  localparam logic [NSRC-1:0] LEVEL_SRC = (NSRC'(1) << SB_RX_THRESH) | (NSRC'(1) << SB_TX_THRESH);
  localparam logic [NSRC-1:0] LATCH_SRC = ~LEVEL_SRC;

  // abort reasons that carry meaning; the rest are kept at zero
  localparam logic [NSRC-1:0] ABRT_KEEP = 12'hEBF;

  // register byte offsets
  localparam int OFS_VIS    = 'h2C;
  localparam int OFS_MASK   = 'h30;
  localparam int OFS_RAW    = 'h34;
  localparam int OFS_RXTHR  = 'h38;
  localparam int OFS_TXTHR  = 'h3C;
  localparam int OFS_CLRALL = 'h40;
  localparam int OFS_ABRT   = 'h80;

  // per-source clear address for a latched source, -1 for level sources
  function automatic int clr_ofs(input int src);
    case (src)
      SB_RX_UNDER:  clr_ofs = 'h44;
      SB_RX_OVER:   clr_ofs = 'h48;
      SB_TX_OVER:   clr_ofs = 'h4C;
      SB_RD_REQ:    clr_ofs = 'h50;
      SB_TX_ABORT:  clr_ofs = 'h54;
      SB_RX_DONE:   clr_ofs = 'h58;
      SB_ACTIVITY:  clr_ofs = 'h5C;
      SB_STOP_SEEN: clr_ofs = 'h60;
      SB_STRT_SEEN: clr_ofs = 'h64;
      SB_GEN_CALL:  clr_ofs = 'h68;
      default:      clr_ofs = -1;
    endcase
  endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N = 12,
  parameter logic [N-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic bit_q;
      // a set in the same cycle as a clear wins
      assign nxt_o[i] = set_i[i] | (bit_q & ~clr_i[i]);
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= nxt_o[i];
      end
      assign q_o[i] = bit_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> q_o[i]); // R6
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R4
      AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
        (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i])); // R2
    end else begin : g_dead
      logic unused_inputs;
      assign unused_inputs = set_i[i] ^ clr_i[i];
      assign nxt_o[i] = 1'b0;
      assign q_o[i]   = 1'b0;
    end
  end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  output logic             rx_hi_o,
  output logic             tx_lo_o,
  output logic             rx_hi_nxt_o,
  output logic             tx_lo_nxt_o
);

  assign rx_hi_nxt_o = (rx_level_i >  rx_thr_i);
  assign tx_lo_nxt_o = (tx_level_i <= tx_thr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hi_o <= 1'b0;
      tx_lo_o <= 1'b0;
    end else begin
      rx_hi_o <= rx_hi_nxt_o;
      tx_lo_o <= tx_lo_nxt_o;
    end
  end

  AST_RX_LAG: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rx_level_i) == rx_level_i && $past(rx_thr_i) == rx_thr_i)
      |-> (rx_hi_o == (rx_level_i > rx_thr_i))); // R8

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture #(
  parameter int AW = 12,
  parameter logic [AW-1:0] KEEP = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic [AW-1:0] reason_i,
  input  logic          clr_i,
  output logic [AW-1:0] reason_o
);

  logic [AW-1:0] kept;
  assign kept = reason_i & KEEP;

  always_ff @(posedge clk) begin
    if (rst)                reason_o <= '0;
    else if (clr_i && cap_i) reason_o <= kept;
    else if (clr_i)          reason_o <= '0;
    else if (cap_i)          reason_o <= reason_o | kept;
  end

  AST_ABRT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cap_i && !clr_i) |=> $stable(reason_o)); // R7
  AST_ABRT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !cap_i) |=> (reason_o == '0)); // R7
  AST_ABRT_RSVD: assert property (@(posedge clk) disable iff (rst)
    ((reason_o & ~KEEP) == '0)); // R7

endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
  import i2c_irq_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]   evt_pulse_i,
  input  logic [NSRC-1:0]   abrt_reason_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  output logic              irq_o
);

  localparam int PAD_W = DATA_W - NSRC;
  localparam int THR_PAD = DATA_W - LVL_W;

  logic [NSRC-1:0]  mask_q, mask_nxt;
  logic [LVL_W-1:0] rx_thr_q, tx_thr_q;
  logic [NSRC-1:0]  lat_q, lat_nxt, clr_vec, clr_sel;
  logic [NSRC-1:0]  lvl_q, lvl_nxt, raw_q, raw_nxt;
  logic [NSRC-1:0]  abrt_q;
  logic             rx_hi, tx_lo, rx_hi_nxt, tx_lo_nxt;
  logic             is_clrall, abrt_clr;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NSRC];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return (ofs >= 0) && (a == ADDR_W'(ofs));
  endfunction

  // ---------------- write side ----------------
  always_comb begin
    mask_nxt = mask_q;
    if (reg_wr_i && hit(reg_addr_i, OFS_MASK)) mask_nxt = reg_wdata_i[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      rx_thr_q <= '0;
      tx_thr_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (reg_wr_i && hit(reg_addr_i, OFS_RXTHR)) rx_thr_q <= reg_wdata_i[LVL_W-1:0];
      if (reg_wr_i && hit(reg_addr_i, OFS_TXTHR)) tx_thr_q <= reg_wdata_i[LVL_W-1:0];
    end
  end

  // ---------------- clear decode ----------------
  assign is_clrall = reg_rd_i && hit(reg_addr_i, OFS_CLRALL);

  for (genvar s = 0; s < NSRC; s++) begin : g_clr
    assign clr_sel[s] = hit(reg_addr_i, clr_ofs(s));
  end

  assign clr_vec  = is_clrall ? LATCH_SRC : (reg_rd_i ? clr_sel : '0);
  assign abrt_clr = clr_vec[SB_TX_ABORT];

  // ---------------- state ----------------
  irq_event_latch #(.N(NSRC), .LIVE(LATCH_SRC)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .set_i (evt_pulse_i & LATCH_SRC),
    .clr_i (clr_vec),
    .q_o   (lat_q),
    .nxt_o (lat_nxt)
  );

  irq_level_track #(.LVL_W(LVL_W)) u_level (
    .clk         (clk),
    .rst         (rst),
    .rx_level_i  (rx_level_i),
    .tx_level_i  (tx_level_i),
    .rx_thr_i    (rx_thr_q),
    .tx_thr_i    (tx_thr_q),
    .rx_hi_o     (rx_hi),
    .tx_lo_o     (tx_lo),
    .rx_hi_nxt_o (rx_hi_nxt),
    .tx_lo_nxt_o (tx_lo_nxt)
  );

  irq_abort_capture #(.AW(NSRC), .KEEP(ABRT_KEEP)) u_abort (
    .clk      (clk),
    .rst      (rst),
    .cap_i    (evt_pulse_i[SB_TX_ABORT]),
    .reason_i (abrt_reason_i),
    .clr_i    (abrt_clr),
    .reason_o (abrt_q)
  );

  always_comb begin
    lvl_q   = '0;
    lvl_nxt = '0;
    lvl_q[SB_RX_THRESH]   = rx_hi;
    lvl_q[SB_TX_THRESH]   = tx_lo;
    lvl_nxt[SB_RX_THRESH] = rx_hi_nxt;
    lvl_nxt[SB_TX_THRESH] = tx_lo_nxt;
  end

  assign raw_q   = lat_q | lvl_q;
  assign raw_nxt = lat_nxt | lvl_nxt;

  // interrupt line registered from the next-state status
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(raw_nxt & mask_nxt);
  end

  // ---------------- read side ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_rd_i) begin
      reg_rdata_o <= '0;
      if (hit(reg_addr_i, OFS_VIS))   reg_rdata_o <= {{PAD_W{1'b0}}, raw_q & mask_q};
      if (hit(reg_addr_i, OFS_MASK))  reg_rdata_o <= {{PAD_W{1'b0}}, mask_q};
      if (hit(reg_addr_i, OFS_RAW))   reg_rdata_o <= {{PAD_W{1'b0}}, raw_q};
      if (hit(reg_addr_i, OFS_RXTHR)) reg_rdata_o <= {{THR_PAD{1'b0}}, rx_thr_q};
      if (hit(reg_addr_i, OFS_TXTHR)) reg_rdata_o <= {{THR_PAD{1'b0}}, tx_thr_q};
      if (hit(reg_addr_i, OFS_ABRT))  reg_rdata_o <= {{PAD_W{1'b0}}, abrt_q};
      if (|clr_sel)                   reg_rdata_o <= {{(DATA_W-1){1'b0}}, |(clr_sel & lat_q)};
    end
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw_q & mask_q)); // R3
  AST_CLRALL_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_clrall |=> (reg_rdata_o == '0)); // R5
  AST_CLRALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (is_clrall && evt_pulse_i == '0) |=> (lat_q == '0 && abrt_q == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && hit(reg_addr_i, OFS_MASK)) |=> $stable(mask_q)); // R9

endmodule

// File: tb/i2c_irq_bank_tb_top.sv
module i2c_irq_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] reg_addr;
  logic          reg_wr, reg_rd;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [11:0]   evt, reason;
  logic [LW-1:0] rx_level, tx_level;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_bank #(.ADDR_W(AW), .DATA_W(DW), .LVL_W(LW)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .reg_addr_i    (reg_addr),
    .reg_wr_i      (reg_wr),
    .reg_wdata_i   (reg_wdata),
    .reg_rd_i      (reg_rd),
    .reg_rdata_o   (reg_rdata),
    .evt_pulse_i   (evt),
    .abrt_reason_i (reason),
    .rx_level_i    (rx_level),
    .tx_level_i    (tx_level),
    .irq_o         (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [11:0] v, input logic [11:0] r);
    evt = v; reason = r;
    @(negedge clk);
    evt = '0; reason = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    reg_read(8'h34, d); chk("R1 raw after reset", d, 32'h0);
    reg_read(8'h2C, d); chk("R1 visible after reset", d, 32'h0);
    reg_read(8'h30, d); chk("R1 mask after reset", d, 32'h0);
    reg_read(8'h80, d); chk("R1 abort after reset", d, 32'h0);
    reg_read(8'h38, d); chk("R1 rx threshold after reset", d, 32'h0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse(12'hFFF, 12'h000);
    reg_read(8'h34, d); chk("R2 all pulses, bits 2 and 4 ignored", d, 32'hFEB);
    @(negedge clk); @(negedge clk);
    reg_read(8'h34, d); chk("R2 bits held", d, 32'hFEB);
    reg_read(8'h40, d); chk("R5 clear-all returns zero", d, 32'h0);
    reg_read(8'h34, d); chk("R5 raw empty after clear-all", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    pulse(12'h201, 12'h000);
    chk("R3 irq low with zero mask", {31'b0, irq}, 32'h0);
    reg_write(8'h30, 32'hFFFF_F200);
    chk("R3 irq rises with mask write", {31'b0, irq}, 32'h1);
    reg_read(8'h2C, d); chk("R3 visible = raw & mask", d, 32'h200);
    reg_write(8'h30, 32'h001);
    reg_read(8'h2C, d); chk("R3 visible other bit", d, 32'h001);
    reg_write(8'h30, 32'h400);
    chk("R3 irq low when masked off", {31'b0, irq}, 32'h0);
    pulse(12'h400, 12'h000);
    chk("R3 irq same edge as event", {31'b0, irq}, 32'h1);
    reg_read(8'h64, d);
    chk("R3 irq drops on clear", {31'b0, irq}, 32'h0);
    reg_write(8'h30, 32'h0);
    reg_read(8'h40, d);
  endtask

  task automatic t_single_clear;
    logic [31:0] d;
    pulse(12'h00B, 12'h000);
    reg_read(8'h44, d); chk("R4 clear returns old bit", d, 32'h1);
    reg_read(8'h34, d); chk("R4 only bit 0 cleared", d, 32'h00A);
    reg_read(8'h44, d); chk("R4 second clear returns zero", d, 32'h0);
    reg_read(8'h4C, d); chk("R4 clear of bit 3", d, 32'h1);
    reg_read(8'h34, d); chk("R4 bit 1 left", d, 32'h002);
    reg_read(8'h48, d);
    reg_read(8'h34, d); chk("R4 bit 1 cleared by 0x48", d, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    pulse(12'h001, 12'h000);
    evt = 12'h001; reg_addr = 8'h44; reg_rd = 1'b1;
    @(negedge clk);
    evt = '0; reg_rd = 1'b0; d = reg_rdata;
    chk("R6 colliding clear returns old bit", d, 32'h1);
    reg_read(8'h34, d); chk("R6 bit survives collision", d, 32'h001);
    evt = 12'h200; reg_addr = 8'h40; reg_rd = 1'b1;
    @(negedge clk);
    evt = '0; reg_rd = 1'b0;
    reg_read(8'h34, d); chk("R6 bit survives clear-all collision", d, 32'h200);
    reg_read(8'h40, d);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    pulse(12'h040, 12'hFFF);
    reg_read(8'h80, d); chk("R7 reserved reason bits dropped", d, 32'hEBF);
    reg_read(8'h34, d); chk("R7 abort latched", d, 32'h040);
    reg_read(8'h40, d);
    pulse(12'h040, 12'h001);
    pulse(12'h040, 12'h008);
    reg_read(8'h80, d); chk("R7 reasons accumulate", d, 32'h009);
    reg_read(8'h58, d);
    reg_read(8'h80, d); chk("R7 other clear leaves reason", d, 32'h009);
    reg_read(8'h54, d); chk("R7 abort clear returns old bit", d, 32'h1);
    reg_read(8'h80, d); chk("R7 reason cleared", d, 32'h0);
    evt = 12'h040; reason = 12'h800; reg_addr = 8'h54; reg_rd = 1'b1;
    @(negedge clk);
    evt = '0; reason = '0; reg_rd = 1'b0;
    reg_read(8'h80, d); chk("R7 new reason kept on collision", d, 32'h800);
    reg_read(8'h34, d); chk("R7 abort bit kept on collision", d, 32'h040);
    reg_read(8'h40, d);
    reg_read(8'h80, d); chk("R7 clear-all empties reason", d, 32'h0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    reg_write(8'h38, 32'h3);
    rx_level = 5'd4;
    @(negedge clk);
    reg_read(8'h34, d); chk("R8 rx above threshold", d, 32'h004);
    reg_read(8'h40, d);
    reg_read(8'h34, d); chk("R8 level not cleared by clear-all", d, 32'h004);
    rx_level = 5'd3;
    @(negedge clk);
    reg_read(8'h34, d); chk("R8 rx at threshold is low", d, 32'h0);
    reg_write(8'h3C, 32'h2);
    tx_level = 5'd2;
    @(negedge clk);
    reg_read(8'h34, d); chk("R8 tx at threshold", d, 32'h010);
    reg_read(8'h3C, d); chk("R8 tx threshold readback", d, 32'h2);
    tx_level = 5'd3;
    @(negedge clk);
    reg_read(8'h34, d); chk("R8 tx above threshold is low", d, 32'h0);
    rx_level = 5'd0;
    reg_write(8'h38, 32'h0);
    reg_write(8'h3C, 32'h0);
    tx_level = 5'd1;
    @(negedge clk);
  endtask

  task automatic t_map;
    logic [31:0] d;
    reg_write(8'h34, 32'hFFF);
    reg_write(8'h2C, 32'hFFF);
    reg_write(8'h80, 32'hFFF);
    reg_read(8'h34, d); chk("R9 status writes ignored", d, 32'h0);
    reg_read(8'h80, d); chk("R9 abort write ignored", d, 32'h0);
    reg_read(8'h30, d); chk("R9 mask untouched by other writes", d, 32'h0);
    reg_read(8'h90, d); chk("R9 unmapped reads zero", d, 32'h0);
    reg_addr = 8'h30; reg_rd = 1'b1;
    @(posedge clk);
    #1 chk("R9 data not before the edge", reg_rdata, 32'h0);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    evt = '0; reason = '0; rx_level = '0; tx_level = 5'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_mask();
    t_single_clear();
    t_same_cycle();
    t_abort();
    t_levels();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule